// File: doc/BRIEF.md
# Logic and Barrel Shift Unit

This block combines a barrel shifter and a bitwise logic stage for a datapath. Operand B first passes through the shifter, which can shift it logically left or right, shift it arithmetically right, rotate it right, or rotate it right by one place through the carry flag. The shifted value then enters one of five two-input logic functions together with operand A, or passes straight through. The shifter produces the carry-out: it is the last bit shifted out, or the incoming carry when nothing was shifted.

All inputs are taken on a clock edge where `in_valid` is high. The result, carry, zero and negative flags are registered on that edge, and `out_valid` pulses for one cycle. The outputs keep their last values until the next valid input arrives. Arithmetic, multiply and divide are not part of this unit.

Top module: `logic_shift_unit`

## Requirements
- R1: `logic_op` selects the function of A and the shifted B (called S): 0 gives A&S, 1 gives A|S, 2 gives A^S, 3 gives A&~S, 4 gives A|~S, and 5, 6 and 7 pass S through unchanged.
- R2: `shift_kind`=1 shifts B left by the amount and fills with zeros. For an amount n from 1 to 32 the carry-out is bit 32-n of B.
- R3: `shift_kind`=2 shifts B right logically and fills with zeros. Carry-out is bit n-1 of B. An amount of 32 gives 0 with carry equal to B[31].
- R4: `shift_kind`=3 shifts B right arithmetically and fills with copies of B[31]. Carry-out is bit n-1 of B. An amount of 32 fills every bit with the sign.
- R5: `shift_kind`=4 rotates B right, so bits leaving bit 0 re-enter at bit 31. Carry-out is the new bit 31. An amount of 32 leaves B unchanged with carry B[31].
- R6: `shift_kind`=5 rotates right by exactly one bit through the carry, whatever the amount: `carry_in` enters bit 31 and the old B[0] becomes carry-out.
- R7: A shift amount of 0 (any kind except 5), or `shift_kind` 0, 6 or 7, leaves B unchanged and passes `carry_in` to carry-out. Amounts above 32 act as 32.
- R8: `zero` is 1 exactly when the registered result is all zeros. `negative` equals result bit 31.
- R9: Result and flags are registered on the rising edge where `in_valid` is 1, and `out_valid` is high for the following cycle only. Without `in_valid`, the outputs hold.
- R10: After a synchronous reset, `out_valid`, `result`, `carry_out`, `zero` and `negative` are all 0.
- R11: A shifted B combines with any logic function, and the carry-out still comes from the shifter whatever the logic function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: capture the operation this edge |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B, the value that is shifted |
| shamt | input | 6 | Shift amount, 0 to 63 (values above 32 act as 32) |
| shift_kind | input | 3 | Shifter mode: 0 none, 1 LSL, 2 LSR, 3 ASR, 4 ROR, 5 RRX |
| logic_op | input | 3 | Logic function (see R1) |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result registered on the previous edge |
| result | output | 32 | Registered result |
| carry_out | output | 1 | Registered carry flag |
| zero | output | 1 | Registered zero flag |
| negative | output | 1 | Registered negative flag |

## Verification
Every result and flag is due exactly one rising edge after the edge that sampled `in_valid`, since a single register stage lies between the inputs and the outputs. The bench drives each operation on a falling edge, removes the strobe on the next falling edge, and samples the outputs there, half a cycle after the capturing edge. On selected vectors it waits one more falling edge to confirm that `out_valid` has dropped and the result has held. The sweep covers every shifter mode with every amount from 0 to 40 on several bit patterns, then every logic function combined with several shift settings.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [2:0] {
    SK_NONE = 3'd0,
    SK_LSL  = 3'd1,
    SK_LSR  = 3'd2,
    SK_ASR  = 3'd3,
    SK_ROR  = 3'd4,
    SK_RRX  = 3'd5
  } shift_kind_e;

  typedef enum logic [2:0] {
    LO_AND  = 3'd0,
    LO_OR   = 3'd1,
    LO_XOR  = 3'd2,
    LO_ANDN = 3'd3,
    LO_ORN  = 3'd4,
    LO_PASS = 3'd5
  } logic_op_e;
endpackage

// File: rtl/lsu_shifter.sv
module lsu_shifter
  import lsu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SW = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SW-1:0]    amount,
  input  logic [2:0]       kind,
  input  logic             cin,
  output logic [WIDTH-1:0] dout,
  output logic             cout
);
  localparam logic [SW-1:0] FULL = SW'(WIDTH);

  logic [SW-1:0]      amt_c;
  logic [WIDTH-1:0]   fill;
  logic [2*WIDTH:0]   right_w;
  logic [2*WIDTH-1:0] left_w;
  shift_kind_e        k;

  always_comb begin
    k       = shift_kind_e'(kind);
    amt_c   = (amount > FULL) ? FULL : amount;
    case (k)
      SK_ASR:  fill = {WIDTH{din[WIDTH-1]}};
      SK_ROR:  fill = din;
      default: fill = '0;
    endcase
    // The bit just below the operand catches the last bit shifted out.
    right_w = {fill, din, 1'b0} >> amt_c;
    left_w  = {{WIDTH{1'b0}}, din} << amt_c;
  end

  always_comb begin
    dout = din;
    cout = cin;
    case (k)
      SK_LSL: if (amt_c != '0) begin
        dout = left_w[WIDTH-1:0];
        cout = left_w[WIDTH];
      end
      SK_LSR, SK_ASR, SK_ROR: if (amt_c != '0) begin
        dout = right_w[WIDTH:1];
        cout = right_w[0];
      end
      SK_RRX: begin
        dout = {cin, din[WIDTH-1:1]};
        cout = din[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lsu_logic.sv
module lsu_logic
  import lsu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] s,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    case (logic_op_e'(op))
      LO_AND:  y = a & s;
      LO_OR:   y = a | s;
      LO_XOR:  y = a ^ s;
      LO_ANDN: y = a & ~s;
      LO_ORN:  y = a | ~s;
      default: y = s;
    endcase
  end
endmodule

// File: rtl/lsu_flags.sv
module lsu_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero,
  output logic             is_neg
);
  assign is_zero = ~|value;
  assign is_neg  = value[WIDTH-1];
endmodule

// File: rtl/logic_shift_unit.sv
module logic_shift_unit
  import lsu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SW = $clog2(WIDTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [SW-1:0]    shamt,
  input  logic [2:0]       shift_kind,
  input  logic [2:0]       logic_op,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zero,
  output logic             negative
);
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] comb_res;
  logic             comb_c;
  logic             comb_z;
  logic             comb_n;

  lsu_shifter #(.WIDTH(WIDTH)) u_shift (
    .din(op_b), .amount(shamt), .kind(shift_kind), .cin(carry_in),
    .dout(shifted), .cout(comb_c)
  );

  lsu_logic #(.WIDTH(WIDTH)) u_logic (
    .a(op_a), .s(shifted), .op(logic_op), .y(comb_res)
  );

  lsu_flags #(.WIDTH(WIDTH)) u_flags (
    .value(comb_res), .is_zero(comb_z), .is_neg(comb_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
      zero      <= 1'b0;
      negative  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= comb_res;
        carry_out <= comb_c;
        zero      <= comb_z;
        negative  <= comb_n;
      end
    end
  end

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drop_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(carry_out));
  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (zero == (result == '0)));
  assert_neg_flag_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (negative == result[WIDTH-1]));
  assert_rrx_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shift_kind == SK_RRX) |=> (carry_out == $past(op_b[0])));
  assert_zero_amount_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shamt == '0 && shift_kind != SK_RRX) |=> (carry_out == $past(carry_in)));
endmodule

// File: tb/logic_shift_unit_bench.sv
`timescale 1ns/1ps
module logic_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [5:0]  shamt = '0;
  logic [2:0]  shift_kind = '0;
  logic [2:0]  logic_op = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out;
  logic        zero;
  logic        negative;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  logic_shift_unit u_logic_shift_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .shamt(shamt), .shift_kind(shift_kind), .logic_op(logic_op),
    .carry_in(carry_in), .out_valid(out_valid), .result(result),
    .carry_out(carry_out), .zero(zero), .negative(negative)
  );

  logic [31:0] pats [6];
  initial begin
    pats[0] = 32'h8000_0001; pats[1] = 32'hDEAD_BEEF; pats[2] = 32'h0000_0000;
    pats[3] = 32'hFFFF_FFFF; pats[4] = 32'h7654_3210; pats[5] = 32'h0F0F_A5A5;
  end

  // Bit-at-a-time reference of the shifter.
  task automatic model_shift(input [2:0] k, input [31:0] b, input [5:0] n,
                             input ci, output [31:0] v, output c);
    int ne;
    ne = (n > 32) ? 32 : int'(n);
    v = b; c = ci;
    if (k == 3'd5) begin
      c = b[0]; v = {ci, b[31:1]};
    end else if (k >= 3'd1 && k <= 3'd4) begin
      for (int i = 0; i < ne; i++) begin
        case (k)
          3'd1: begin c = v[31]; v = {v[30:0], 1'b0}; end
          3'd2: begin c = v[0];  v = {1'b0, v[31:1]}; end
          3'd3: begin c = v[0];  v = {v[31], v[31:1]}; end
          default: begin c = v[0]; v = {v[0], v[31:1]}; end
        endcase
      end
    end
  endtask

  function automatic [31:0] model_logic(input [2:0] op, input [31:0] a, input [31:0] s);
    case (op)
      3'd0: return a & s;
      3'd1: return a | s;
      3'd2: return a ^ s;
      3'd3: return a & ~s;
      3'd4: return a | ~s;
      default: return s;
    endcase
  endfunction

  task automatic run(input [2:0] k, input [2:0] op, input [31:0] a, input [31:0] b,
                     input [5:0] n, input ci, input string tag, input bit hold);
    logic [31:0] sv, ev;
    logic ec, ez, en;
    model_shift(k, b, n, ci, sv, ec);
    ev = model_logic(op, a, sv);
    ez = (ev == 32'd0);
    en = ev[31];
    @(negedge clk);
    op_a = a; op_b = b; shamt = n; shift_kind = k; logic_op = op;
    carry_in = ci; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (!out_valid || result !== ev || carry_out !== ec || zero !== ez || negative !== en) begin
      fails++;
      $display("FAIL %s k=%0d op=%0d n=%0d: v/res/c/z/n=%b/%h/%b/%b/%b expected 1/%h/%b/%b/%b",
               tag, k, op, n, out_valid, result, carry_out, zero, negative, ev, ec, ez, en);
    end
    if (hold) begin
      op_b = ~b; carry_in = ~ci;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== ev || carry_out !== ec) begin
        fails++;
        $display("FAIL R9 hold: v/res/c=%b/%h/%b expected 0/%h/%b",
                 out_valid, result, carry_out, ev, ec);
      end
    end
  endtask

  function automatic string kind_tag(input [2:0] k, input [5:0] n);
    if (k == 3'd5) return "R6";
    if (k == 3'd0 || k > 3'd5 || n == 0 || n > 32) return "R7";
    case (k)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 32'd0 || carry_out !== 1'b0 ||
        zero !== 1'b0 || negative !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: v/res/c/z/n=%b/%h/%b/%b/%b expected 0/0/0/0/0",
               out_valid, result, carry_out, zero, negative);
    end
    rst = 1'b0;

    // Shifter sweep, pass-through logic: R2..R7, flags R8.
    for (int k = 0; k < 8; k++)
      for (int n = 0; n <= 40; n++)
        for (int p = 0; p < 6; p++)
          run(3'(k), 3'd5, 32'h0, pats[p], 6'(n), 1'((n + p) & 1),
              kind_tag(3'(k), 6'(n)), (n == 7 && p == 1));

    // Logic sweep with pre-shifted B: R1, R11, flags R8.
    for (int op = 0; op < 8; op++)
      for (int pa = 0; pa < 6; pa++)
        for (int pb = 0; pb < 6; pb++) begin
          run(3'd0, 3'(op), pats[pa], pats[pb], 6'd0, 1'(pb & 1), "R1", 1'b0);
          run(3'd1, 3'(op), pats[pa], pats[pb], 6'd4, 1'b0, "R11", 1'b0);
          run(3'd4, 3'(op), pats[pa], pats[pb], 6'd8, 1'b1, "R11", 1'b0);
          run(3'd5, 3'(op), pats[pa], pats[pb], 6'd3, 1'(pa & 1), "R11", 1'b0);
        end

    // Flag corners: R8.
    run(3'd0, 3'd0, 32'h0000_FFFF, 32'hFFFF_0000, 6'd0, 1'b0, "R8", 1'b1);
    run(3'd0, 3'd5, 32'h0, 32'h8000_0000, 6'd0, 1'b0, "R8", 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule